// File: doc/BRIEF.md
# Reference-Clock One-Second Tick Generator

This block turns a reference clock whose frequency is not a power of two into a one-pulse-per-period tick. A binary counter runs on the reference clock. Terminal count is detected by ANDing only the counter bits that are set in the detect constant, instead of comparing the full word. The constant is normally the reference frequency in hertz, so one tick arrives each second.

When the terminal count is seen, a synchronous clear is raised. The clear lasts a configurable number of cycles, counting the detect cycle as the first. The counter is held at zero while the clear is active. The clock edge that ends the clear counts as the first count of the next period. A clear of K cycles therefore lengthens the period by K-1 counts, which models the counts that a long reset pulse steals. A clear-active status output shows the clear window. The asynchronous active-low reset is released synchronously through a two-stage synchronizer.

Top module: `sec_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick_o` and `clr_active_o` are both 0.
- R2: After `rst_n` rises, `tick_o` first asserts in the cycle that follows clock edge number DETECT_MASK+2, counting the first rising edge with `rst_n` high as edge 1.
- R3: `tick_o` is high for exactly one cycle per period.
- R4: Consecutive rising transitions of `tick_o` are exactly DETECT_MASK + CLR_CYCLES - 1 cycles apart.
- R5: `clr_active_o` rises in the same cycle as `tick_o` and stays high for exactly CLR_CYCLES consecutive cycles.
- R6: With CLR_CYCLES = 1, `clr_active_o` is high only in the tick cycle, and ticks are exactly DETECT_MASK cycles apart, so no count is lost.
- R7: Asserting `rst_n` low mid-period clears `tick_o` and `clr_active_o` at once, without waiting for a clock edge. After release, the period restarts from zero as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_o | output | 1 | One-cycle pulse once per period |
| clr_active_o | output | 1 | High while the synchronous counter clear is active |

## Verification
Both outputs are decoded from state in the same cycle, with no output register. The tick therefore appears in the cycle right after the edge that loads the terminal count, and the clear status rises in that same cycle. The first tick after reset comes two edges late because of the reset synchronizer, which gives DETECT_MASK+2 edges after release. The bench drives inputs on falling edges and samples on falling edges. It counts edges from a known release point, so each expected tick, period and clear length is checked in its exact cycle. Three instances with different detect masks and clear lengths are measured over three periods each. The asynchronous reset is checked a fraction of a cycle after it asserts, before any clock edge.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Width of the clear-hold down-counter for a given clear length.
  function automatic int unsigned hold_width(int unsigned clr_cycles);
    int unsigned w;
    w = (clr_cycles > 1) ? $clog2(clr_cycles) : 1;
    return (w < 1) ? 1 : w;
  endfunction

  // Number of set bits in a detect constant (size of the AND tree).
  function automatic int unsigned mask_terms(logic [31:0] mask);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(mask[i]);
    return n;
  endfunction

endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tick_term_detect.sv
module tick_term_detect #(
  parameter int unsigned     CNT_W = 24,
  parameter logic [CNT_W-1:0] MASK = CNT_W'(50000)
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  // Bits clear in MASK are forced high, so the AND covers only set bits.
  logic [CNT_W-1:0] term;

  for (genvar i = 0; i < CNT_W; i++) begin : g_term
    assign term[i] = cnt[i] | ~MASK[i];
  end

  assign hit = &term;

endmodule

// File: rtl/tick_clear_stretch.sv
module tick_clear_stretch #(
  parameter int unsigned CLR_CYCLES = 2,
  parameter int unsigned HOLD_W     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic clr_active,
  output logic clr_last
);

  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(CLR_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;
  logic              hold_en;
  logic              busy;

  assign busy       = (hold_q != '0);
  assign clr_active = hit | busy;
  assign clr_last   = (hold_q == HOLD_ONE);

  always_comb begin
    hold_en = hit | busy;
    hold_d  = hold_q;
    if (hit) begin
      hold_d = HOLD_LOAD;
    end else if (busy) begin
      hold_d = hold_q - HOLD_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_active,
  input  logic             clr_last,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // The edge that ends the clear counts as the first count of the period.
  always_comb begin
    if (clr_last) begin
      cnt_d = CNT_ONE;
    end else if (clr_active) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
  parameter int unsigned      CNT_W       = 24,
  parameter logic [CNT_W-1:0] DETECT_MASK = CNT_W'(50000),
  parameter int unsigned      CLR_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic clr_active_o
);

  localparam int unsigned HOLD_W = tick_pkg::hold_width(CLR_CYCLES);

  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             clr_active;
  logic             clr_last;

  tick_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  tick_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_active (clr_active),
    .clr_last   (clr_last),
    .cnt        (cnt)
  );

  tick_term_detect #(
    .CNT_W (CNT_W),
    .MASK  (DETECT_MASK)
  ) u_detect (
    .cnt (cnt),
    .hit (hit)
  );

  if (CLR_CYCLES <= 1) begin : g_clr_single
    assign clr_active = hit;
    assign clr_last   = hit;
  end else begin : g_clr_multi
    tick_clear_stretch #(
      .CLR_CYCLES (CLR_CYCLES),
      .HOLD_W     (HOLD_W)
    ) u_stretch (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .hit        (hit),
      .clr_active (clr_active),
      .clr_last   (clr_last)
    );
  end

  // Async path: the port reset forces the outputs low without an edge.
  assign tick_o       = hit & rst_n;
  assign clr_active_o = clr_active & rst_n;

endmodule

// File: rtl/sec_tick_gen_chk.sv
module sec_tick_gen_chk #(
  parameter int unsigned PERIOD = 50001,
  parameter int unsigned CLR    = 2
) (
  input logic clk,
  input logic rst_n,
  input logic tick_o,
  input logic clr_active_o
);

  logic [31:0] gap_q;
  logic        seen_q;
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      gap_q  <= tick_o ? 32'd1 : ((gap_q == 32'hFFFF_FFFF) ? gap_q : gap_q + 32'd1);
      seen_q <= seen_q | tick_o;
      run_q  <= clr_active_o ? run_q + 32'd1 : 32'd0;
    end
  end

  // R1: reset forces both outputs low
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet : assert (!tick_o && !clr_active_o);
    end
  end

  a_r3_tick_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    (PERIOD > 1 && tick_o) |=> !tick_o);

  a_r4_tick_period : assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && seen_q) |-> gap_q == 32'(PERIOD));

  a_r5_clear_with_tick : assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> clr_active_o);

  a_r5_clear_rise_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_active_o) |-> tick_o);

  a_r5_clear_length : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_active_o) |-> run_q == 32'(CLR));

endmodule

bind sec_tick_gen sec_tick_gen_chk #(
  .PERIOD (DETECT_MASK + CLR_CYCLES - 1),
  .CLR    (CLR_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_o       (tick_o),
  .clr_active_o (clr_active_o)
);

// File: tb/sec_tick_gen_tb.sv
module sec_tick_gen_tb;

  localparam int unsigned A_MASK = 100; // bits 6,5,2
  localparam int unsigned A_CLR  = 3;
  localparam int unsigned B_MASK = 13;  // bits 3,2,0
  localparam int unsigned B_CLR  = 1;
  localparam int unsigned C_MASK = 40;  // bits 5,3
  localparam int unsigned C_CLR  = 7;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] mask;
    logic [7:0]  clr;
  } vec_t;

  localparam vec_t VEC [3] = '{
    '{sel: 2'd0, mask: 16'(A_MASK), clr: 8'(A_CLR)},
    '{sel: 2'd1, mask: 16'(B_MASK), clr: 8'(B_CLR)},
    '{sel: 2'd2, mask: 16'(C_MASK), clr: 8'(C_CLR)}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] tick_v;
  logic [2:0] clr_v;
  int         checks;
  int         errors;

  sec_tick_gen #(.CNT_W(24), .DETECT_MASK(24'(A_MASK)), .CLR_CYCLES(A_CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_v[0]), .clr_active_o(clr_v[0]));
  sec_tick_gen #(.CNT_W(24), .DETECT_MASK(24'(B_MASK)), .CLR_CYCLES(B_CLR)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_v[1]), .clr_active_o(clr_v[1]));
  sec_tick_gen #(.CNT_W(24), .DETECT_MASK(24'(C_MASK)), .CLR_CYCLES(C_CLR)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_v[2]), .clr_active_o(clr_v[2]));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Release reset on a falling edge, then find each instance's first tick.
  task automatic release_and_first(input string tag);
    int first [3];
    int masks [3];
    masks = '{A_MASK, B_MASK, C_MASK};
    first = '{0, 0, 0};
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk);
      for (int d = 0; d < 3; d++) begin
        if (tick_v[d] && first[d] == 0) first[d] = n;
      end
    end
    for (int d = 0; d < 3; d++) begin
      chk(first[d] == masks[d] + 2, tag, first[d], masks[d] + 2);
    end
  endtask

  // Follow one instance over three periods.
  task automatic measure(input int sel, input int mask, input int clr);
    int    per;
    string ptag;
    per  = mask + clr - 1;
    ptag = (clr == 1) ? "R6 period" : "R4 period";
    for (int w = 0; w < 1000 && !tick_v[sel]; w++) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      int run;
      bit in_run;
      bit done;
      int n;
      run = clr_v[sel] ? 1 : 0;
      in_run = 1'b1;
      done = 1'b0;
      n = 0;
      chk(clr_v[sel] == 1'b1, "R5 clear starts with tick", int'(clr_v[sel]), 1);
      while (!done && n < 1000) begin
        @(negedge clk);
        n++;
        if (n == 1) chk(tick_v[sel] == 1'b0, "R3 tick width", int'(tick_v[sel]), 0);
        if (in_run) begin
          if (clr_v[sel]) run++;
          else begin
            in_run = 1'b0;
            chk(run == clr, (clr == 1) ? "R6 clear length" : "R5 clear length", run, clr);
          end
        end
        if (tick_v[sel] && n > 1) begin
          chk(n == per, ptag, n, per);
          done = 1'b1;
        end
      end
      if (!done) chk(1'b0, ptag, n, per);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    for (int d = 0; d < 3; d++) begin
      chk(tick_v[d] == 1'b0, "R1 tick in reset", int'(tick_v[d]), 0);
      chk(clr_v[d] == 1'b0, "R1 clear in reset", int'(clr_v[d]), 0);
    end
    // R2: first tick latency after release
    release_and_first("R2 first tick");
    // R4, R5, R3, R6 over the vector table
    for (int v = 0; v < 3; v++) begin
      measure(int'(VEC[v].sel), int'(VEC[v].mask), int'(VEC[v].clr));
    end
    // R7: async reset in the middle of a long clear
    for (int w = 0; w < 1000 && !tick_v[2]; w++) @(negedge clk);
    #1;
    chk(clr_v[2] == 1'b1, "R7 clear before reset", int'(clr_v[2]), 1);
    rst_n = 1'b0;
    #0.5;
    chk(clr_v[2] == 1'b0, "R7 async clear drop", int'(clr_v[2]), 0);
    chk(tick_v == 3'b000, "R7 async tick drop", int'(tick_v), 0);
    repeat (3) @(negedge clk);
    release_and_first("R7 restart");
    measure(0, A_MASK, A_CLR);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule